// File: doc/BRIEF.md
# Off-Chip Data Memory Bus Controller

This block sits between a processor's data-memory access port and a group of shared I/O pins. Each processor request is routed either to the on-chip data memory, which answers in the same cycle, or to an external memory bus. The block runs one read or write transfer on that bus with strobe timing set by configuration. The routing follows a 2-bit memory mode. The pins can be arranged in two ways: multiplexed, where the low address byte is latched through an address-latch pulse and then the same pins carry the data, or separate, where address and data have their own pins.

The block drives the pins only while an external transfer is running. At every other time, each pin's value and enable come straight from the general-purpose port latch inputs, which software normally parks at logic 1. Open-drain versus push-pull drive is handled outside the block; it only supplies a value and an enable per pin.

Pin vector layout (PIN_W = AW+DW+3, defaults AW=16, DW=8):
- bits [7:0]: data, or the multiplexed address/data pins.
- bits [15:8]: the separate low-address pins.
- bits [23:16]: the high-address pins.
- bit 24: ALE, active high.
- bit 25: RD_n, active low.
- bit 26: WR_n, active low.

Top module: `emif_ctrl`

## Requirements
- R1: `cfg_mode` routes each request. 00 sends every address on-chip. 11 sends every address off-chip. 01 and 10 send addresses below 0x2000 on-chip and addresses from 0x2000 upward off-chip.
- R2: For an on-chip request, `onchip_en` and `cpu_ready` are high in the same cycle as `cpu_req`, and `cpu_rdata` equals `onchip_rdata`. The pins stay equal to the port latch inputs throughout.
- R3: While no external transfer is in progress, `pin_o`/`pin_oe` equal `port_lat_o`/`port_lat_oe`. The cycle after the ready cycle of an external transfer, the pins are back on the latch values.
- R4: With `cfg_mux`=1, the transfer opens with ALE driven high for `cfg_ale_len`+1 cycles while the low address is on pins [7:0]. One more cycle follows with ALE low and the address still held, and only then does the data phase begin.
- R5: With `cfg_mux`=0, the low address is driven on pins [15:8] and ALE stays low. With `cfg_mux`=1, pins [15:8] keep their latch values.
- R6: The setup, strobe and hold phases last `cfg_setup`, `cfg_pulse` and `cfg_hold` cycles, with 0 counting as 1. The ready cycle is the last hold cycle, so an external transfer takes (mux ? `cfg_ale_len`+2 : 0) + setup + pulse + hold cycles.
- R7: During an external read, RD_n is low for the strobe phase and the data pin enables are 0 through the data phase. `cpu_rdata` in the ready cycle equals the value that `pin_data_i` held in the last strobe cycle.
- R8: During an external write, `cpu_wdata` is driven with enables on pins [7:0] through the data phase and WR_n is low for the strobe phase. RD_n stays high throughout; during a read, WR_n stays high throughout.
- R9: In mode 10, the high-address pins carry `cfg_bank`. In every other mode they carry `cpu_addr[15:8]`. All address pins are driven with enable 1 while the transfer runs.
- R10: `cpu_ready` is high for exactly one cycle per request. The request is held until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Access request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Access address (also read by the on-chip memory) |
| cpu_wdata | input | 8 | Write data (also read by the on-chip memory) |
| cpu_ready | output | 1 | Access complete; read data valid |
| cpu_rdata | output | 8 | Read data |
| onchip_en | output | 1 | On-chip memory access strobe |
| onchip_rdata | input | 8 | On-chip memory read data |
| cfg_mux | input | 1 | 1 = multiplexed address/data pins |
| cfg_mode | input | 2 | Memory mode (see R1) |
| cfg_ale_len | input | 2 | ALE width minus one |
| cfg_setup | input | 4 | Setup cycles (0 means 1) |
| cfg_pulse | input | 4 | Strobe cycles (0 means 1) |
| cfg_hold | input | 4 | Hold cycles (0 means 1) |
| cfg_bank | input | 8 | High address byte used in mode 10 |
| port_lat_o | input | 27 | Port latch output values |
| port_lat_oe | input | 27 | Port latch output enables |
| pin_o | output | 27 | Pin output values |
| pin_oe | output | 27 | Pin output enables |
| pin_data_i | input | 8 | Data pin input values |

## Verification
The assertions assume the configuration inputs do not change while an external transfer runs. They also assume the processor keeps `cpu_req`, address, direction and write data steady until it sees ready. Under those assumptions, a read never drives the data pins during its strobe, ALE never overlaps a strobe, and the pins are released right after completion. The bench changes configuration, latch values and request fields only while the block is idle between accesses, and it keeps `pin_data_i` constant for the length of each transfer.

// File: rtl/emif_pkg.sv
package emif_pkg;

    typedef enum logic [1:0] {
        MM_ONCHIP     = 2'b00,
        MM_SPLIT      = 2'b01,
        MM_SPLIT_BANK = 2'b10,
        MM_OFFCHIP    = 2'b11
    } mem_mode_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ALE,
        PH_AHOLD,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } phase_e;

    // Phase length with zero promoted to the one-cycle minimum
    function automatic logic [3:0] at_least_one(input logic [3:0] v);
        return (v == 4'd0) ? 4'd1 : v;
    endfunction

endpackage

// File: rtl/emif_route.sv
module emif_route
    import emif_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter logic [AW-1:0] ONCHIP_LIMIT = 16'h2000
) (
    input  logic [AW-1:0]    addr,
    input  logic [1:0]       mode,
    input  logic [AW-DW-1:0] bank,
    output logic             offchip,
    output logic [AW-1:0]    ext_addr
);
    localparam int HI_W = AW - DW;

    always_comb begin
        unique case (mem_mode_e'(mode))
            MM_ONCHIP:  offchip = 1'b0;
            MM_OFFCHIP: offchip = 1'b1;
            default:    offchip = (addr >= ONCHIP_LIMIT);
        endcase
        ext_addr = addr;
        if (mem_mode_e'(mode) == MM_SPLIT_BANK)
            ext_addr[AW-1:DW] = bank[HI_W-1:0];
    end
endmodule

// File: rtl/emif_seq.sv
module emif_seq
    import emif_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    input  logic             cfg_mux,
    input  logic [1:0]       cfg_ale_len,
    input  logic [3:0]       cfg_setup,
    input  logic [3:0]       cfg_pulse,
    input  logic [3:0]       cfg_hold,
    input  logic [DW-1:0]    pin_data_i,
    output logic             busy,
    output logic             done,
    output logic [DW-1:0]    rdata,
    output logic [AW+DW+2:0] own_mask,
    output logic [AW+DW+2:0] own_o,
    output logic [AW+DW+2:0] own_oe
);
    localparam int PIN_W = AW + DW + 3;
    localparam int P_ALE = AW + DW;
    localparam int P_RD  = AW + DW + 1;
    localparam int P_WR  = AW + DW + 2;

    typedef struct packed {
        phase_e        ph;
        logic [3:0]    cnt;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
    } seq_t;

    seq_t seq_d, seq_q;
    logic done_d;

    always_comb begin
        seq_d  = seq_q;
        done_d = 1'b0;
        unique case (seq_q.ph)
            PH_IDLE: if (start) begin
                seq_d.we    = we;
                seq_d.addr  = addr;
                seq_d.wdata = wdata;
                if (cfg_mux) begin
                    seq_d.ph  = PH_ALE;
                    seq_d.cnt = {2'b00, cfg_ale_len};
                end else begin
                    seq_d.ph  = PH_SETUP;
                    seq_d.cnt = at_least_one(cfg_setup) - 4'd1;
                end
            end
            PH_ALE: begin
                if (seq_q.cnt == 4'd0) seq_d.ph = PH_AHOLD;
                else                   seq_d.cnt = seq_q.cnt - 4'd1;
            end
            PH_AHOLD: begin
                seq_d.ph  = PH_SETUP;
                seq_d.cnt = at_least_one(cfg_setup) - 4'd1;
            end
            PH_SETUP: begin
                if (seq_q.cnt == 4'd0) begin
                    seq_d.ph  = PH_STROBE;
                    seq_d.cnt = at_least_one(cfg_pulse) - 4'd1;
                end else seq_d.cnt = seq_q.cnt - 4'd1;
            end
            PH_STROBE: begin
                if (seq_q.cnt == 4'd0) begin
                    if (!seq_q.we) seq_d.rdata = pin_data_i;
                    seq_d.ph  = PH_HOLD;
                    seq_d.cnt = at_least_one(cfg_hold) - 4'd1;
                end else seq_d.cnt = seq_q.cnt - 4'd1;
            end
            PH_HOLD: begin
                if (seq_q.cnt == 4'd0) begin
                    done_d   = 1'b1;
                    seq_d.ph = PH_IDLE;
                end else seq_d.cnt = seq_q.cnt - 4'd1;
            end
            default: seq_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy  = (seq_q.ph != PH_IDLE);
    assign done  = done_d;
    assign rdata = seq_q.rdata;

    // Pin drive while the transfer owns the bus
    always_comb begin
        own_mask = '0;
        own_o    = '0;
        own_oe   = '0;
        if (busy) begin
            own_mask[DW-1:0]      = '1;
            own_mask[2*DW-1:DW]   = {DW{~cfg_mux}};
            own_mask[PIN_W-1:2*DW] = '1;
        end
        own_o[AW+DW-1:2*DW]  = seq_q.addr[AW-1:DW];
        own_oe[AW+DW-1:2*DW] = '1;
        own_o[2*DW-1:DW]     = seq_q.addr[DW-1:0];
        own_oe[2*DW-1:DW]    = '1;
        own_o[P_ALE]  = (seq_q.ph == PH_ALE);
        own_o[P_RD]   = ~((seq_q.ph == PH_STROBE) && !seq_q.we);
        own_o[P_WR]   = ~((seq_q.ph == PH_STROBE) && seq_q.we);
        own_oe[P_ALE] = 1'b1;
        own_oe[P_RD]  = 1'b1;
        own_oe[P_WR]  = 1'b1;
        if (seq_q.ph == PH_ALE || seq_q.ph == PH_AHOLD) begin
            own_o[DW-1:0]  = seq_q.addr[DW-1:0];
            own_oe[DW-1:0] = '1;
        end else begin
            own_o[DW-1:0]  = seq_q.wdata;
            own_oe[DW-1:0] = {DW{seq_q.we}};
        end
    end

    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R3
    AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R10
endmodule

// File: rtl/emif_pinmux.sv
module emif_pinmux #(
    parameter int PIN_W = 27
) (
    input  logic [PIN_W-1:0] own_mask,
    input  logic [PIN_W-1:0] own_o,
    input  logic [PIN_W-1:0] own_oe,
    input  logic [PIN_W-1:0] lat_o,
    input  logic [PIN_W-1:0] lat_oe,
    output logic [PIN_W-1:0] pin_o,
    output logic [PIN_W-1:0] pin_oe
);
    for (genvar i = 0; i < PIN_W; i++) begin : g_pin
        assign pin_o[i]  = own_mask[i] ? own_o[i]  : lat_o[i];
        assign pin_oe[i] = own_mask[i] ? own_oe[i] : lat_oe[i];
    end
endmodule

// File: rtl/emif_ctrl.sv
module emif_ctrl
    import emif_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter logic [AW-1:0] ONCHIP_LIMIT = 16'h2000,
    localparam int PIN_W = AW + DW + 3,
    localparam int HI_W  = AW - DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_req,
    input  logic             cpu_we,
    input  logic [AW-1:0]    cpu_addr,
    input  logic [DW-1:0]    cpu_wdata,
    output logic             cpu_ready,
    output logic [DW-1:0]    cpu_rdata,
    output logic             onchip_en,
    input  logic [DW-1:0]    onchip_rdata,
    input  logic             cfg_mux,
    input  logic [1:0]       cfg_mode,
    input  logic [1:0]       cfg_ale_len,
    input  logic [3:0]       cfg_setup,
    input  logic [3:0]       cfg_pulse,
    input  logic [3:0]       cfg_hold,
    input  logic [HI_W-1:0]  cfg_bank,
    input  logic [PIN_W-1:0] port_lat_o,
    input  logic [PIN_W-1:0] port_lat_oe,
    output logic [PIN_W-1:0] pin_o,
    output logic [PIN_W-1:0] pin_oe,
    input  logic [DW-1:0]    pin_data_i
);
    localparam int P_ALE = AW + DW;
    localparam int P_RD  = AW + DW + 1;
    localparam int P_WR  = AW + DW + 2;

    logic             offchip, busy, done, start;
    logic [AW-1:0]    ext_addr;
    logic [DW-1:0]    ext_rdata;
    logic [PIN_W-1:0] own_mask, own_o, own_oe;

    emif_route #(.AW(AW), .DW(DW), .ONCHIP_LIMIT(ONCHIP_LIMIT)) u_route (
        .addr(cpu_addr), .mode(cfg_mode), .bank(cfg_bank),
        .offchip(offchip), .ext_addr(ext_addr)
    );

    assign start     = cpu_req && !busy && offchip;
    assign onchip_en = cpu_req && !busy && !offchip;
    assign cpu_ready = onchip_en || done;
    assign cpu_rdata = onchip_en ? onchip_rdata : ext_rdata;

    emif_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .we(cpu_we),
        .addr(ext_addr), .wdata(cpu_wdata), .cfg_mux(cfg_mux),
        .cfg_ale_len(cfg_ale_len), .cfg_setup(cfg_setup),
        .cfg_pulse(cfg_pulse), .cfg_hold(cfg_hold),
        .pin_data_i(pin_data_i), .busy(busy), .done(done),
        .rdata(ext_rdata), .own_mask(own_mask), .own_o(own_o),
        .own_oe(own_oe)
    );

    emif_pinmux #(.PIN_W(PIN_W)) u_pinmux (
        .own_mask(own_mask), .own_o(own_o), .own_oe(own_oe),
        .lat_o(port_lat_o), .lat_oe(port_lat_oe),
        .pin_o(pin_o), .pin_oe(pin_oe)
    );

    AST_ONCHIP_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        onchip_en |-> (pin_o == port_lat_o && pin_oe == port_lat_oe)); // R2
    AST_READ_RELEASES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pin_o[P_RD]) |-> (pin_oe[DW-1:0] == '0)); // R7
    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (pin_o[P_RD] || pin_o[P_WR])); // R8
    AST_ALE_OUTSIDE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pin_o[P_ALE]) |-> (pin_o[P_RD] && pin_o[P_WR])); // R4
    AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && offchip) |=> !done); // R10
endmodule

// File: tb/emif_ctrl_test.sv
module emif_ctrl_test;
    localparam int PIN_W = 27;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_req = 0, cpu_we = 0;
    logic [15:0] cpu_addr = 0;
    logic [7:0]  cpu_wdata = 0, onchip_rdata = 0, pin_data_i = 0, cfg_bank = 0;
    logic cfg_mux = 0;
    logic [1:0] cfg_mode = 0, cfg_ale_len = 0;
    logic [3:0] cfg_setup = 0, cfg_pulse = 0, cfg_hold = 0;
    logic [PIN_W-1:0] port_lat_o = '1, port_lat_oe = '0;
    logic cpu_ready, onchip_en;
    logic [7:0] cpu_rdata;
    logic [PIN_W-1:0] pin_o, pin_oe;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    emif_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .cpu_rdata(cpu_rdata), .onchip_en(onchip_en), .onchip_rdata(onchip_rdata),
        .cfg_mux(cfg_mux), .cfg_mode(cfg_mode), .cfg_ale_len(cfg_ale_len),
        .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse), .cfg_hold(cfg_hold),
        .cfg_bank(cfg_bank), .port_lat_o(port_lat_o), .port_lat_oe(port_lat_oe),
        .pin_o(pin_o), .pin_oe(pin_oe), .pin_data_i(pin_data_i)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit exp_off(input logic [1:0] m, input logic [15:0] a);
        if (m == 2'b00) return 1'b0;
        if (m == 2'b11) return 1'b1;
        return a >= 16'h2000;
    endfunction

    function automatic int f1(input logic [3:0] v);
        return (v == 0) ? 1 : int'(v);
    endfunction

    function automatic logic [7:0] ext_val(input logic [7:0] hi, input logic [7:0] lo);
        return hi ^ lo ^ 8'hA5;
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic access(input bit we, input logic [15:0] a, input logic [7:0] wd);
        logic [7:0] hi, lo;
        int pre, lat, n, ale_cnt, rd_cnt, wr_cnt, first_strobe;
        bit bad_hi, bad_mid, bad_data, bad_ad, bad_ale, off;
        off = exp_off(cfg_mode, a);
        hi  = (cfg_mode == 2'b10) ? cfg_bank : a[15:8];
        lo  = a[7:0];
        cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        onchip_rdata = 8'($urandom);
        pin_data_i = ext_val(hi, lo);
        cpu_req = 1'b1;
        #1;
        check(cpu_ready == !off, "R1 routing", cpu_ready, !off);
        if (!off) begin
            check(onchip_en && cpu_rdata == onchip_rdata, "R2 onchip data", cpu_rdata, onchip_rdata);
            check(pin_o == port_lat_o && pin_oe == port_lat_oe, "R2 pins untouched", pin_o, port_lat_o);
            @(negedge clk);
            cpu_req = 1'b0;
            #1;
            check(!cpu_ready, "R10 single ready", cpu_ready, 0);
            return;
        end
        pre = cfg_mux ? int'(cfg_ale_len) + 2 : 0;
        lat = pre + f1(cfg_setup) + f1(cfg_pulse) + f1(cfg_hold);
        n = 0; ale_cnt = 0; rd_cnt = 0; wr_cnt = 0; first_strobe = -1;
        bad_hi = 0; bad_mid = 0; bad_data = 0; bad_ad = 0; bad_ale = 0;
        while (n < 200) begin
            @(negedge clk);
            if (pin_o[24]) begin
                ale_cnt++;
                if (!(n < pre - 1 && pin_o[7:0] == lo && pin_oe[7:0] == 8'hFF)) bad_ale = 1;
            end
            if (cfg_mux && n == pre - 1 &&
                !(pin_o[24] == 0 && pin_o[7:0] == lo && pin_oe[7:0] == 8'hFF)) bad_ad = 1;
            if (pin_o[23:16] != hi || pin_oe[23:16] != 8'hFF) bad_hi = 1;
            if (cfg_mux) begin
                if (pin_o[15:8] != port_lat_o[15:8] || pin_oe[15:8] != port_lat_oe[15:8]) bad_mid = 1;
            end else if (pin_o[15:8] != lo || pin_oe[15:8] != 8'hFF) bad_mid = 1;
            if (n >= pre) begin
                if (we && !(pin_o[7:0] == wd && pin_oe[7:0] == 8'hFF)) bad_data = 1;
                if (!we && pin_oe[7:0] != 8'h00) bad_data = 1;
            end
            if (!pin_o[25] || !pin_o[26]) begin
                if (first_strobe < 0) first_strobe = n;
            end
            if (!pin_o[25]) rd_cnt++;
            if (!pin_o[26]) wr_cnt++;
            n++;
            if (cpu_ready) break;
        end
        check(n == lat, "R6 latency", n, lat);
        check(ale_cnt == (cfg_mux ? int'(cfg_ale_len) + 1 : 0) && !bad_ale, "R4/R5 ALE width", ale_cnt, cfg_ale_len);
        check(!bad_ad, "R4 address hold after ALE", bad_ad, 0);
        check(!bad_mid, "R5 low address pins", bad_mid, 0);
        check(!bad_hi, "R9 high address pins", bad_hi, 0);
        check(first_strobe == pre + f1(cfg_setup), "R6 setup length", first_strobe, pre + f1(cfg_setup));
        if (we) begin
            check(wr_cnt == f1(cfg_pulse) && rd_cnt == 0, "R8 write strobe", wr_cnt, f1(cfg_pulse));
            check(!bad_data, "R8 write data driven", bad_data, 0);
        end else begin
            check(rd_cnt == f1(cfg_pulse) && wr_cnt == 0, "R7 read strobe", rd_cnt, f1(cfg_pulse));
            check(!bad_data, "R7 data released", bad_data, 0);
            check(cpu_rdata == ext_val(hi, lo), "R7 read data", cpu_rdata, ext_val(hi, lo));
        end
        cpu_req = 1'b0;
        @(negedge clk);
        check(pin_o == port_lat_o && pin_oe == port_lat_oe, "R3 pins revert", pin_o, port_lat_o);
        check(!cpu_ready, "R10 single ready", cpu_ready, 0);
    endtask

    task automatic set_cfg(input bit mux, input logic [1:0] mode, input logic [1:0] ale,
                           input logic [3:0] s, input logic [3:0] p, input logic [3:0] h);
        cfg_mux = mux; cfg_mode = mode; cfg_ale_len = ale;
        cfg_setup = s; cfg_pulse = p; cfg_hold = h;
        cfg_bank = 8'($urandom);
        port_lat_o = PIN_W'({$urandom, $urandom});
        port_lat_oe = PIN_W'({$urandom, $urandom});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check(!cpu_ready && !onchip_en, "R10 reset ready", cpu_ready, 0);
        check(pin_o == port_lat_o && pin_oe == port_lat_oe, "R3 reset pins", pin_o, port_lat_o);
        rst_n = 1'b1;
        @(negedge clk);
        // Directed corners
        set_cfg(1, 2'b01, 2'd0, 4'd0, 4'd0, 4'd0); access(0, 16'h1FFF, 8'h00);
        set_cfg(1, 2'b01, 2'd3, 4'd0, 4'd0, 4'd0); access(0, 16'h2000, 8'h00);
        set_cfg(0, 2'b00, 2'd0, 4'd1, 4'd1, 4'd1); access(1, 16'hFFFF, 8'h3C);
        set_cfg(0, 2'b11, 2'd1, 4'd15, 4'd15, 4'd15); access(1, 16'h0000, 8'hC3);
        set_cfg(1, 2'b10, 2'd2, 4'd2, 4'd3, 4'd1); access(0, 16'hABCD, 8'h00);
        set_cfg(0, 2'b10, 2'd0, 4'd0, 4'd2, 4'd0); access(1, 16'h1234, 8'h5A);
        // Constrained random
        for (int k = 0; k < 80; k++) begin
            logic [15:0] a;
            a = 16'($urandom);
            if (($urandom % 4) == 0) a = 16'h1FFE + 16'($urandom % 4);
            set_cfg(1'($urandom), 2'($urandom), 2'($urandom),
                    4'($urandom), 4'($urandom), 4'($urandom));
            access(1'($urandom), a, 8'($urandom));
        end
        finish_run();
    end
endmodule